// File: doc/BRIEF.md
# FIFO ECC Error Counter Bank

This block is a register-mapped status unit for the three buffer memories of a CAN controller. The three memories are a high-priority transmit FIFO, an ordinary transmit FIFO and a receive FIFO. The error-correction logic beside each memory emits a one-cycle pulse for every corrected (single-bit) event and for every uncorrectable (double-bit) event. This bank counts those pulses in saturating 16-bit counters, two per FIFO packed into one read-only word. It also keeps one sticky interrupt status bit per FIFO and error class.

Software reads the counts and clears them per FIFO by writing strobe bits to a configuration register. It chooses which status bits drive the interrupt line through an enable register. It acknowledges status bits by writing ones to a clear register. Access is through a simple synchronous port: one address, a write strobe with write data, and a read strobe. Read data is registered and appears after the clock edge that samples the read strobe.

Top module: `ecc_err_counter_bank`

## Requirements
- R1: A FIFO's counter word holds its single-bit count in bits [15:0] and its double-bit count in bits [31:16]. Each count rises by one for every clock cycle in which its event pulse is high. FIFO index 0 is the high-priority TX FIFO, index 1 is the ordinary TX FIFO and index 2 is the RX FIFO.
- R2: Each 16-bit count stops at 0xFFFF and never wraps to zero.
- R3: The register map is as follows. 0xC8 is the configuration register. The counter words are at 0xCC (FIFO 0), 0xD0 (FIFO 1) and 0xD4 (FIFO 2). Interrupt status is at 0xB0, interrupt enable at 0xB4 and interrupt clear at 0xB8. A read of any other address, or of 0xB8, returns zero.
- R4: Writing 1 to configuration bit 0, 1 or 2 clears both counts of FIFO 0, 1 or 2 respectively. The configuration register reads back as zero. Writes to the counter or status addresses have no effect.
- R5: When a counter clear and an event for the same FIFO fall in the same cycle, that FIFO's counts end at zero.
- R6: The status bits are placed as follows: bit 18 for a FIFO 0 single-bit event, bit 19 for a FIFO 0 double-bit event, bit 20 and bit 21 for FIFO 1, and bit 22 and bit 23 for FIFO 2. A status bit is set by every event, even when its count is saturated, and stays set until it is cleared. All other status bits read as zero.
- R7: The enable register stores bits [23:18] and reads them back, with all other bits zero. The irq output is high exactly when some status bit and its enable bit are both set.
- R8: Writing ones to the clear register clears the status bits at the same positions. An event in the same cycle as a clear of its bit leaves the bit set.
- R9: A synchronous active-high reset zeroes every count, every status bit and the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; rdData updates at the next edge |
| rdData | output | 32 | Registered read data |
| eccSingle | input | 3 | Per-FIFO single-bit event pulses (index 0 high-priority TX, 1 TX, 2 RX) |
| eccDouble | input | 3 | Per-FIFO double-bit event pulses |
| irq | output | 1 | Interrupt: any enabled status bit set |

## Verification
A wrong count appears at the ports only when the counter word is read. It shows on rdData one cycle after the read strobe, as an off-by-one value, a wrapped value after saturation, or a nonzero value after a clear. A wrong status or enable bit shows on irq in the same cycle it goes wrong, if the matching enable is set. Otherwise it shows on the next read of the status register. The bench keeps a cycle-exact model of every count and status bit. It reads registers continually during random traffic, so a corrupted value is reported on the first read that follows it.

// File: rtl/ecc_cnt_pkg.sv
package ecc_cnt_pkg;
  localparam int NUM_FIFO   = 3;
  localparam int CNT_WIDTH  = 16;
  localparam int ADDR_WIDTH = 8;
  localparam int IRQ_LSB    = 18;
  localparam int NUM_IRQ    = 2 * NUM_FIFO;

  localparam logic [ADDR_WIDTH-1:0] OFS_STAT = 8'hB0;
  localparam logic [ADDR_WIDTH-1:0] OFS_EN   = 8'hB4;
  localparam logic [ADDR_WIDTH-1:0] OFS_CLR  = 8'hB8;
  localparam logic [ADDR_WIDTH-1:0] OFS_CFG  = 8'hC8;
  localparam logic [ADDR_WIDTH-1:0] OFS_CNT0 = 8'hCC;

  // Strobes from register decode to the counting datapath
  typedef struct packed {
    logic [NUM_FIFO-1:0] clrFifo;
    logic [NUM_IRQ-1:0]  clrIrq;
    logic                loadEn;
    logic [NUM_IRQ-1:0]  enVal;
  } ctrl_strobe_t;

  function automatic logic [ADDR_WIDTH-1:0] cntOfs(input int idx);
    return ADDR_WIDTH'(int'(OFS_CNT0) + 4 * idx);
  endfunction
endpackage

// File: rtl/ecc_reg_ctrl.sv
module ecc_reg_ctrl
  import ecc_cnt_pkg::*;
#(
  parameter int ADDR_W = ADDR_WIDTH,
  parameter int DATA_W = 2 * CNT_WIDTH
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_strobe_t      strb
);
  logic cfgHit, clrHit, enHit;

  always_comb begin
    cfgHit = wrEn && (addr == OFS_CFG);
    clrHit = wrEn && (addr == OFS_CLR);
    enHit  = wrEn && (addr == OFS_EN);
    strb.clrFifo = cfgHit ? wrData[NUM_FIFO-1:0] : '0;
    strb.clrIrq  = clrHit ? wrData[IRQ_LSB +: NUM_IRQ] : '0;
    strb.loadEn  = enHit;
    strb.enVal   = wrData[IRQ_LSB +: NUM_IRQ];
  end

  // R4: a configuration strobe exists only on a write to the configuration address
  always_comb begin
    a_r4_strobe_only_on_cfg_write: assert ((strb.clrFifo == '0) || (wrEn && addr == OFS_CFG));
  end
endmodule

// File: rtl/ecc_cnt_datapath.sv
module ecc_cnt_datapath
  import ecc_cnt_pkg::*;
#(
  parameter int N_FIFO = NUM_FIFO,
  parameter int CNT_W  = CNT_WIDTH,
  parameter int ADDR_W = ADDR_WIDTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_strobe_t         strb,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rdEn,
  input  logic [N_FIFO-1:0]    eccSingle,
  input  logic [N_FIFO-1:0]    eccDouble,
  output logic [2*CNT_W-1:0]   rdData,
  output logic                 irq
);
  localparam int DATA_W = 2 * CNT_W;
  localparam int N_IRQ  = 2 * N_FIFO;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cntSgl [N_FIFO];
  logic [CNT_W-1:0]  cntDbl [N_FIFO];
  logic [N_IRQ-1:0]  status;
  logic [N_IRQ-1:0]  enable;
  logic [N_IRQ-1:0]  setVec;
  logic [DATA_W-1:0] rdMux;

  for (genvar i = 0; i < N_FIFO; i++) begin : g_fifo
    assign setVec[2*i]   = eccSingle[i];
    assign setVec[2*i+1] = eccDouble[i];

    always_ff @(posedge clk) begin
      if (rst || strb.clrFifo[i]) begin
        cntSgl[i] <= '0;
        cntDbl[i] <= '0;
      end else begin
        if (eccSingle[i] && cntSgl[i] != CNT_MAX) cntSgl[i] <= cntSgl[i] + 1'b1;
        if (eccDouble[i] && cntDbl[i] != CNT_MAX) cntDbl[i] <= cntDbl[i] + 1'b1;
      end
    end

    a_r1_single_increments: assert property (@(posedge clk) disable iff (rst)
      (eccSingle[i] && !strb.clrFifo[i] && cntSgl[i] != CNT_MAX)
        |=> cntSgl[i] == CNT_W'($past(cntSgl[i]) + 1));
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (cntDbl[i] == CNT_MAX && !strb.clrFifo[i]) |=> cntDbl[i] == CNT_MAX);
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
      strb.clrFifo[i] |=> (cntSgl[i] == '0 && cntDbl[i] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~strb.clrIrq) | setVec;
      if (strb.loadEn) enable <= strb.enVal;
    end
  end

  assign irq = |(status & enable);

  always_comb begin
    rdMux = '0;
    if (addr == OFS_STAT) rdMux[IRQ_LSB +: N_IRQ] = status;
    if (addr == OFS_EN)   rdMux[IRQ_LSB +: N_IRQ] = enable;
    for (int i = 0; i < N_FIFO; i++) begin
      if (addr == cntOfs(i)) rdMux = {cntDbl[i], cntSgl[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (setVec != '0) |=> ((status & $past(setVec)) == $past(setVec)));
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (strb.clrIrq == '0) |=> ((status & $past(status)) == $past(status)));
  a_r7_irq_follows_enabled_event: assert property (@(posedge clk) disable iff (rst)
    ((|(setVec & enable)) && !strb.loadEn) |=> irq);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (status == '0 && enable == '0 && !irq));
endmodule

// File: rtl/ecc_err_counter_bank.sv
module ecc_err_counter_bank
  import ecc_cnt_pkg::*;
#(
  parameter int N_FIFO = NUM_FIFO,
  parameter int CNT_W  = CNT_WIDTH,
  parameter int ADDR_W = ADDR_WIDTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [2*CNT_W-1:0]  wrData,
  input  logic                rdEn,
  output logic [2*CNT_W-1:0]  rdData,
  input  logic [N_FIFO-1:0]   eccSingle,
  input  logic [N_FIFO-1:0]   eccDouble,
  output logic                irq
);
  ctrl_strobe_t strb;

  ecc_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(2*CNT_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .strb(strb)
  );

  ecc_cnt_datapath #(.N_FIFO(N_FIFO), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .rdEn(rdEn),
    .eccSingle(eccSingle), .eccDouble(eccDouble), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/sim_ecc_err_counter_bank.sv
module sim_ecc_err_counter_bank;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = '0;
  logic        wrEn = 0;
  logic [31:0] wrData = '0;
  logic        rdEn = 0;
  logic [31:0] rdData;
  logic [2:0]  eccSingle = '0;
  logic [2:0]  eccDouble = '0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // bench model
  logic [15:0] mSgl [3];
  logic [15:0] mDbl [3];
  logic [5:0]  mSt;
  logic [5:0]  mEn;

  always #4 clk = ~clk;

  ecc_err_counter_bank u0 (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .eccSingle(eccSingle), .eccDouble(eccDouble), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'hB0: return {8'h0, mSt, 18'h0};
      8'hB4: return {8'h0, mEn, 18'h0};
      8'hCC: return {mDbl[0], mSgl[0]};
      8'hD0: return {mDbl[1], mSgl[1]};
      8'hD4: return {mDbl[2], mSgl[2]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelStep(input logic [2:0] s, input logic [2:0] d, input logic wr,
                           input logic [7:0] a, input logic [31:0] wd);
    logic [5:0] setV, clrV;
    for (int i = 0; i < 3; i++) begin
      if (wr && a == 8'hC8 && wd[i]) begin
        mSgl[i] = '0; mDbl[i] = '0;
      end else begin
        if (s[i] && mSgl[i] != 16'hFFFF) mSgl[i]++;
        if (d[i] && mDbl[i] != 16'hFFFF) mDbl[i]++;
      end
      setV[2*i] = s[i]; setV[2*i+1] = d[i];
    end
    clrV = (wr && a == 8'hB8) ? wd[23:18] : 6'h0;
    mSt = (mSt & ~clrV) | setV;
    if (wr && a == 8'hB4) mEn = wd[23:18];
  endtask

  // one bus cycle: drive at negedge, model after the edge, compare at next negedge
  task automatic cyc(input logic [2:0] s, input logic [2:0] d, input logic wr, input logic rd,
                     input logic [7:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    eccSingle = s; eccDouble = d; wrEn = wr; rdEn = rd; addr = a; wrData = wd;
    exp = modelRead(a);
    @(posedge clk);
    modelStep(s, d, wr, a, wd);
    @(negedge clk);
    if (rd) check(tag, rdData, exp);
    check("R7 irq", {31'h0, irq}, {31'h0, |(mSt & mEn)});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(3'b0, 3'b0, 1'b0, 1'b1, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd);
    cyc(3'b0, 3'b0, 1'b1, 1'b0, a, wd, "wr");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'hB0, 8'hB4, 8'hB8, 8'hC8, 8'hCC, 8'hD0, 8'hD4, 8'hDC};
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) begin mSgl[i] = '0; mDbl[i] = '0; end
    mSt = '0; mEn = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R9 reset state, R3 unmapped reads
    rd(8'hCC, "R9 cnt0 reset"); rd(8'hD0, "R9 cnt1 reset"); rd(8'hD4, "R9 cnt2 reset");
    rd(8'hB0, "R9 status reset"); rd(8'hB4, "R9 enable reset");
    rd(8'hDC, "R3 unmapped read");

    // R1 field placement and increment per FIFO
    cyc(3'b001, 3'b000, 0, 0, 8'h0, 0, "R1");
    cyc(3'b011, 3'b010, 0, 0, 8'h0, 0, "R1");
    cyc(3'b000, 3'b110, 0, 0, 8'h0, 0, "R1");
    rd(8'hCC, "R1 cnt hp-tx"); rd(8'hD0, "R1 cnt tx"); rd(8'hD4, "R1 cnt rx");
    // R6 mapping of status bits
    rd(8'hB0, "R6 status map");
    // R7 enable readback and irq
    wr(8'hB4, 32'hFFFF_FFFF);
    rd(8'hB4, "R7 enable readback");
    // R8 clear and set-wins
    wr(8'hB8, 32'h0004_0000);
    rd(8'hB0, "R8 w1c");
    cyc(3'b100, 3'b000, 1, 0, 8'hB8, 32'h0040_0000, "R8");
    rd(8'hB0, "R8 set wins over clear");
    // R4 config clears, reads zero, writes to counters ignored
    wr(8'hCC, 32'h1234_5678);
    rd(8'hCC, "R4 counter write ignored");
    wr(8'hB0, 32'hFFFF_FFFF);
    rd(8'hB0, "R4 status write ignored");
    rd(8'hC8, "R4 cfg reads zero");
    wr(8'hC8, 32'h0000_0001);
    rd(8'hCC, "R4 cfg bit0 clears hp-tx");
    rd(8'hD0, "R4 other fifo kept");
    // R5 clear beats same-cycle event
    cyc(3'b010, 3'b010, 1, 0, 8'hC8, 32'h0000_0002, "R5");
    rd(8'hD0, "R5 clear wins");

    // R2 saturation on RX FIFO
    wr(8'hB8, 32'hFFFF_FFFF);
    for (int k = 0; k < 65540; k++) cyc(3'b100, 3'b100, 0, 0, 8'h0, 0, "R2");
    rd(8'hD4, "R2 saturated");
    wr(8'hB8, 32'h00C0_0000);
    cyc(3'b100, 3'b100, 0, 0, 8'h0, 0, "R6");
    rd(8'hB0, "R6 set while saturated");
    rd(8'hD4, "R2 still saturated");

    // constrained random traffic
    for (int k = 0; k < 6000; k++) begin
      logic [2:0] s, d;
      logic w;
      logic [7:0] a;
      logic [31:0] wd;
      s = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      d = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 9) == 0);
      a = addrs[$urandom_range(0, 7)];
      wd = $urandom();
      cyc(s, d, w, !w, a, wd, "R1 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule